// File: doc/BRIEF.md
# Equalizer Command Serializer Controller

This block sits on the host side of a digitally controlled stereo graphic equalizer. It drives the equalizer's three-wire control port: a serial clock, a serial data line and a latch strobe. The host hands it one command at a time through a ready/valid handshake. A command holds a band number, a range bit for each channel, a boost/cut flag and a gain from 0 to 12 dB.

The controller turns the gain into the equalizer's irregular 6-bit gain pattern and builds two 8-bit words, a band word and a gain word. It shifts each word out least significant bit first on a divided-down serial clock. It then parks the clock low and pulses the strobe, and clock and data stay frozen while the strobe is high. The equalizer remembers the selected band, so the controller leaves out the band word whenever it would repeat the last one sent. A gain-only change then costs half the line time.

Timing is set by two parameters counted in system clock cycles. `HALF_CYC` is each serial clock half period, and it also sets the setup, hold and strobe-delay gaps. `STB_CYC` is the strobe width. With a 250 MHz system clock, the defaults of 250 give a 500 kHz serial clock and 1 µs minimum spacing.

Top module: `eq_cmd_serializer`

## Requirements
- R1: While reset is active `ser_clk`, `ser_data`, `ser_stb`, `busy` and `req_ready` are all low. Within 4 cycles after reset is released `req_ready` is high and `busy` is low.
- R2: The gain word is bit 7 = 0, bit 6 = `req_boost`, and bits 5..0 = gain code. The gain codes (bits 5..0) are: 0 dB 000000, 1 dB 100000, 2 dB 010000, 3 dB 001000, 4 dB 000100, 5 dB 000010, 6 dB 010010, 7 dB 101010, 8 dB 010110, 9 dB 000001, 10 dB 101001, 11 dB 101101, 12 dB 101111.
- R3: The band word is bit 7 = 1, bit 6 = 0, bit 5 = `req_rng_a`, bit 4 = `req_rng_b` and bits 3..0 = `req_band`. A range bit of 1 selects the ±6 dB range for that channel.
- R4: Each word goes out bit 0 first, with each bit sampled on a rising edge of `ser_clk`. The clock low and high phases each last `HALF_CYC` cycles. `ser_data` changes only while `ser_clk` is low.
- R5: After the eighth rising edge the clock returns low. `ser_stb` rises `HALF_CYC` cycles after that falling edge and stays high for `STB_CYC` cycles. `ser_clk` is low and `ser_clk`/`ser_data` do not change while `ser_stb` is high.
- R6: A command that needs a band word sends the band word with its strobe first, then the gain word with its own strobe.
- R7: The band word is left out when it is identical to the band word of the last accepted command. The first command after reset always sends it.
- R8: A gain request above 12 dB is sent as the 12 dB code.
- R9: `req_ready` is the inverse of `busy` outside reset. `busy` is high from the cycle after acceptance until `HALF_CYC` cycles after the final strobe falls. Requests offered while busy are ignored and produce no serial traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller can accept a command |
| req_band | input | 4 | Band code |
| req_rng_a | input | 1 | Channel A range, 1 = ±6 dB |
| req_rng_b | input | 1 | Channel B range, 1 = ±6 dB |
| req_boost | input | 1 | 1 = boost, 0 = cut |
| req_db | input | 4 | Gain magnitude in dB, clamped to 12 |
| busy | output | 1 | Command in progress |
| ser_clk | output | 1 | Serial clock to the equalizer |
| ser_data | output | 1 | Serial data to the equalizer |
| ser_stb | output | 1 | Latch strobe to the equalizer |

## Verification
The bench builds the controller with `HALF_CYC` = 3 and `STB_CYC` = 5. Because the two values differ, a strobe width taken from the wrong parameter shows up as a width error, and a full two-word command takes about 120 cycles. The short phases let a single run measure every half period, gap and strobe width across all thirteen gain codes, the clamp, both range bits, repeated and changed band words, and the band-word resend after a reset.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

  localparam int WORD_W = 8;
  localparam int BAND_W = 4;
  localparam int DB_W   = 4;
  localparam int CODE_W = 6;
  localparam int DB_MAX = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_STROBE,
    ST_RECOV
  } eqs_state_e;

  // dB magnitude to the equalizer's 6-bit gain pattern (bits 5..0)
  function automatic logic [CODE_W-1:0] db_to_code(input logic [DB_W-1:0] db);
    logic [CODE_W-1:0] c;
    case (db)
      4'd0:    c = 6'b000000;
      4'd1:    c = 6'b100000;
      4'd2:    c = 6'b010000;
      4'd3:    c = 6'b001000;
      4'd4:    c = 6'b000100;
      4'd5:    c = 6'b000010;
      4'd6:    c = 6'b010010;
      4'd7:    c = 6'b101010;
      4'd8:    c = 6'b010110;
      4'd9:    c = 6'b000001;
      4'd10:   c = 6'b101001;
      4'd11:   c = 6'b101101;
      default: c = 6'b101111;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/eqs_word_build.sv
module eqs_word_build
  import eqs_pkg::*;
(
  input  logic [BAND_W-1:0] band,
  input  logic              rng_a,
  input  logic              rng_b,
  input  logic              boost,
  input  logic [DB_W-1:0]   db,
  output logic [WORD_W-1:0] band_word,
  output logic [WORD_W-1:0] gain_word
);

  logic [DB_W-1:0] db_sat;

  always_comb begin
    db_sat    = (db > DB_W'(DB_MAX)) ? DB_W'(DB_MAX) : db;
    band_word = {1'b1, 1'b0, rng_a, rng_b, band};
    gain_word = {1'b0, boost, db_to_code(db_sat)};
  end

endmodule

// File: rtl/eqs_band_memo.sv
module eqs_band_memo
  import eqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic              match
);

  logic [WORD_W-1:0] mem_q, mem_d;
  logic              vld_q, vld_d;

  always_comb begin
    mem_d = load ? word_in : mem_q;
    vld_d = vld_q | load;
    match = vld_q && (mem_q == word_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      vld_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      vld_q <= vld_d;
    end
  end

  // R7: a stored word is only ever reported as a repeat once a load has happened
  assert_no_match_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !$past(vld_q)) |-> $past(load));

endmodule

// File: rtl/eqs_phase_timer.sv
module eqs_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = run && (cnt_q == lim);
    cnt_d = (!run || done) ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/eqs_serial_fsm.sv
module eqs_serial_fsm
  import eqs_pkg::*;
#(
  parameter int HALF_CYC = 250,
  parameter int STB_CYC  = 250,
  parameter int TW       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_band,
  input  logic [WORD_W-1:0] band_word,
  input  logic [WORD_W-1:0] gain_word,
  input  logic              tm_done,
  output logic              tm_run,
  output logic [TW-1:0]     tm_lim,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_stb
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  eqs_state_e        st_q, st_d;
  logic [WORD_W-1:0] wd_q, wd_d;
  logic [WORD_W-1:0] gn_q, gn_d;
  logic              pend_q, pend_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_nx;
  logic              ph_q, ph_d;
  logic              sclk_q, sclk_d;
  logic              sdat_q, sdat_d;
  logic              stb_q, stb_d;
  logic              en;

  always_comb begin
    busy   = (st_q != ST_IDLE);
    tm_run = busy;
    tm_lim = (st_q == ST_STROBE) ? TW'(STB_CYC - 1) : TW'(HALF_CYC - 1);
    en     = (st_q == ST_IDLE) ? start : tm_done;
    idx_nx = idx_q + IDX_W'(1);
  end

  always_comb begin
    st_d   = st_q;
    wd_d   = wd_q;
    gn_d   = gn_q;
    pend_d = pend_q;
    idx_d  = idx_q;
    ph_d   = ph_q;
    sclk_d = sclk_q;
    sdat_d = sdat_q;
    stb_d  = stb_q;
    case (st_q)
      ST_IDLE: begin
        st_d  = ST_SHIFT;
        idx_d = '0;
        ph_d  = 1'b0;
        gn_d  = gain_word;
        if (skip_band) begin
          wd_d   = gain_word;
          pend_d = 1'b0;
          sdat_d = gain_word[0];
        end else begin
          wd_d   = band_word;
          pend_d = 1'b1;
          sdat_d = band_word[0];
        end
      end
      ST_SHIFT: begin
        if (!ph_q) begin
          ph_d   = 1'b1;
          sclk_d = 1'b1;
        end else begin
          ph_d   = 1'b0;
          sclk_d = 1'b0;
          if (idx_q == IDX_LAST) begin
            st_d = ST_GAP;
          end else begin
            idx_d  = idx_nx;
            sdat_d = wd_q[idx_nx];
          end
        end
      end
      ST_GAP: begin
        st_d  = ST_STROBE;
        stb_d = 1'b1;
      end
      ST_STROBE: begin
        st_d  = ST_RECOV;
        stb_d = 1'b0;
      end
      ST_RECOV: begin
        if (pend_q) begin
          st_d   = ST_SHIFT;
          wd_d   = gn_q;
          pend_d = 1'b0;
          idx_d  = '0;
          ph_d   = 1'b0;
          sdat_d = gn_q[0];
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wd_q   <= '0;
      gn_q   <= '0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
      stb_q  <= 1'b0;
    end else if (en) begin
      st_q   <= st_d;
      wd_q   <= wd_d;
      gn_q   <= gn_d;
      pend_q <= pend_d;
      idx_q  <= idx_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
      sdat_q <= sdat_d;
      stb_q  <= stb_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = sdat_q;
  assign ser_stb  = stb_q;

  // R4: data only moves while the serial clock is low
  assert_data_moves_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> !ser_clk);

  // R5: clock parked low during the strobe
  assert_clk_low_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |-> !ser_clk);

  // R5: clock and data frozen while the strobe stays high
  assert_frozen_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_stb && $past(ser_stb)) |-> ($stable(ser_data) && $stable(ser_clk)));

  // R9: strobe only inside a busy command
  assert_strobe_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_stb || ser_clk) |-> busy);

endmodule

// File: rtl/eq_cmd_serializer.sv
module eq_cmd_serializer
  import eqs_pkg::*;
#(
  parameter int HALF_CYC = 250,
  parameter int STB_CYC  = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BAND_W-1:0] req_band,
  input  logic              req_rng_a,
  input  logic              req_rng_b,
  input  logic              req_boost,
  input  logic [DB_W-1:0]   req_db,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_stb
);

  localparam int LIM_MAX = (HALF_CYC > STB_CYC) ? HALF_CYC : STB_CYC;
  localparam int TW      = $clog2(LIM_MAX) + 1;

  logic [1:0]        rsync_q;
  logic              rst_s_n;
  logic [WORD_W-1:0] band_word, gain_word;
  logic              skip_band, start;
  logic              tm_run, tm_done;
  logic [TW-1:0]     tm_lim;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign req_ready = rst_s_n && !busy;
  assign start     = req_valid && req_ready;

  eqs_word_build u_build (
    .band      (req_band),
    .rng_a     (req_rng_a),
    .rng_b     (req_rng_b),
    .boost     (req_boost),
    .db        (req_db),
    .band_word (band_word),
    .gain_word (gain_word)
  );

  eqs_band_memo u_memo (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (start),
    .word_in (band_word),
    .match   (skip_band)
  );

  eqs_phase_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (tm_run),
    .lim   (tm_lim),
    .done  (tm_done)
  );

  eqs_serial_fsm #(
    .HALF_CYC (HALF_CYC),
    .STB_CYC  (STB_CYC),
    .TW       (TW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .skip_band (skip_band),
    .band_word (band_word),
    .gain_word (gain_word),
    .tm_done   (tm_done),
    .tm_run    (tm_run),
    .tm_lim    (tm_lim),
    .busy      (busy),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_stb   (ser_stb)
  );

  // R9: an accepted request makes the controller busy on the next cycle
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_ready) |=> busy);

  // R9: busy only falls with the line idle
  assert_busy_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy) |-> (!ser_stb && !ser_clk));

endmodule

// File: tb/test_eq_cmd_serializer.sv
`timescale 1ns/1ps
module test_eq_cmd_serializer;

  localparam int HALF = 3;
  localparam int STB  = 5;
  localparam int NV   = 16;

  logic       clk, rst_n;
  logic       req_valid, req_ready;
  logic [3:0] req_band;
  logic       req_rng_a, req_rng_b, req_boost;
  logic [3:0] req_db;
  logic       busy, ser_clk, ser_data, ser_stb;

  int checks, errors;
  int mchk, merr;
  bit finished;

  eq_cmd_serializer #(.HALF_CYC(HALF), .STB_CYC(STB)) i_eq_cmd_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_band(req_band), .req_rng_a(req_rng_a), .req_rng_b(req_rng_b),
    .req_boost(req_boost), .req_db(req_db), .busy(busy),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_stb(ser_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {band, rng_a, rng_b, boost, db, nwords, word0, word1}
  localparam logic [28:0] VEC [NV] = '{
    {4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  2'd2, 8'h80, 8'h00},
    {4'd3,  1'b0, 1'b0, 1'b1, 4'd1,  2'd2, 8'h83, 8'h60},
    {4'd3,  1'b0, 1'b0, 1'b0, 4'd2,  2'd1, 8'h10, 8'h00},
    {4'd3,  1'b0, 1'b0, 1'b1, 4'd7,  2'd1, 8'h6A, 8'h00},
    {4'd3,  1'b1, 1'b0, 1'b0, 4'd12, 2'd2, 8'hA3, 8'h2F},
    {4'd14, 1'b1, 1'b1, 1'b1, 4'd9,  2'd2, 8'hBE, 8'h41},
    {4'd14, 1'b1, 1'b1, 1'b1, 4'd15, 2'd1, 8'h6F, 8'h00},
    {4'd14, 1'b1, 1'b1, 1'b0, 4'd0,  2'd1, 8'h00, 8'h00},
    {4'd7,  1'b0, 1'b1, 1'b0, 4'd10, 2'd2, 8'h97, 8'h29},
    {4'd7,  1'b0, 1'b1, 1'b1, 4'd11, 2'd1, 8'h6D, 8'h00},
    {4'd1,  1'b0, 1'b0, 1'b1, 4'd6,  2'd2, 8'h81, 8'h52},
    {4'd1,  1'b0, 1'b0, 1'b1, 4'd8,  2'd1, 8'h56, 8'h00},
    {4'd1,  1'b0, 1'b0, 1'b0, 4'd3,  2'd1, 8'h08, 8'h00},
    {4'd1,  1'b0, 1'b0, 1'b1, 4'd4,  2'd1, 8'h44, 8'h00},
    {4'd1,  1'b0, 1'b0, 1'b0, 4'd5,  2'd1, 8'h02, 8'h00},
    {4'd1,  1'b0, 1'b0, 1'b0, 4'd13, 2'd1, 8'h2F, 8'h00}
  };

  // serial capture: bits on rising ser_clk, word closed on rising ser_stb
  logic [7:0] cap [0:255];
  int         ncap, nbit;
  logic [7:0] sh;

  initial begin ncap = 0; nbit = 0; sh = '0; end

  always @(posedge ser_clk or posedge ser_stb) begin
    if (ser_stb) begin
      mchk++;
      if (nbit != 8) begin
        merr++;
        $display("FAIL R4: bits before strobe actual %0d expected 8", nbit);
      end
      cap[ncap[7:0]] = sh;
      ncap++;
      nbit = 0;
    end else begin
      sh = {ser_data, sh[7:1]};
      nbit++;
    end
  end

  // line timing monitor, sampled away from the active edge
  int  cyc, t_rise, t_fall, t_srise, bits_in_word;
  logic pclk, pdat, pstb;
  initial begin
    cyc = 0; t_rise = 0; t_fall = 0; t_srise = 0; bits_in_word = 0;
    pclk = 0; pdat = 0; pstb = 0; mchk = 0; merr = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_clk && !pclk) begin
        if (bits_in_word > 0) begin
          mchk++;
          if (cyc - t_fall != HALF) begin
            merr++;
            $display("FAIL R4: clock low phase actual %0d expected %0d", cyc - t_fall, HALF);
          end
        end
        t_rise = cyc;
        bits_in_word++;
      end
      if (!ser_clk && pclk) begin
        mchk++;
        if (cyc - t_rise != HALF) begin
          merr++;
          $display("FAIL R4: clock high phase actual %0d expected %0d", cyc - t_rise, HALF);
        end
        t_fall = cyc;
      end
      if (ser_data != pdat && ser_clk) begin
        merr++;
        $display("FAIL R4: data changed with clock high actual 1 expected 0");
      end
      if (ser_stb && !pstb) begin
        mchk++;
        if (cyc - t_fall != HALF) begin
          merr++;
          $display("FAIL R5: fall-to-strobe gap actual %0d expected %0d", cyc - t_fall, HALF);
        end
        t_srise = cyc;
        bits_in_word = 0;
      end
      if (!ser_stb && pstb) begin
        mchk++;
        if (cyc - t_srise != STB) begin
          merr++;
          $display("FAIL R5: strobe width actual %0d expected %0d", cyc - t_srise, STB);
        end
      end
      if (ser_stb && (ser_clk || (pstb && ser_data != pdat))) begin
        merr++;
        $display("FAIL R5: clock/data moved in strobe actual clk=%0d expected 0", ser_clk);
      end
    end
    pclk = ser_clk; pdat = ser_data; pstb = ser_stb;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] b, input logic ra, input logic rb,
                      input logic bo, input logic [3:0] d);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_band = b; req_rng_a = ra; req_rng_b = rb; req_boost = bo; req_db = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1 && req_ready == 1'b0, "R9 busy after accept", {busy, req_ready}, 2'b10);
    guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic expect_words(input int base, input int nw, input logic [7:0] w0,
                              input logic [7:0] w1, input string req);
    check(ncap - base == nw, {req, " word count"}, ncap - base, nw);
    if (ncap - base >= 1) check(cap[base[7:0]] == w0, {req, " first word"}, cap[base[7:0]], w0);
    if (nw == 2 && ncap - base >= 2)
      check(cap[8'(base + 1)] == w1, {req, " second word"}, cap[8'(base + 1)], w1);
  endtask

  initial begin
    finished = 0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + mchk, errors + merr);
      $finish;
    end
  end

  initial begin
    int base;
    checks = 0; errors = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_band = '0; req_rng_a = 0; req_rng_b = 0;
    req_boost = 0; req_db = '0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    check({ser_clk, ser_data, ser_stb, busy, req_ready} == 5'b0, "R1 outputs in reset",
          {ser_clk, ser_data, ser_stb, busy, req_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !busy, "R1 ready after reset", {req_ready, busy}, 2'b10);

    // table walk: R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      base = ncap;
      send(VEC[i][28:25], VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:18]);
      expect_words(base, int'(VEC[i][17:16]), VEC[i][15:8], VEC[i][7:0],
                   $sformatf("R2/R3/R6/R7/R8 vec%0d", i));
    end

    // R9: requests while busy are ignored
    base = ncap;
    @(negedge clk);
    req_band = 4'd9; req_rng_a = 0; req_rng_b = 0; req_boost = 1; req_db = 4'd1;
    req_valid = 1'b1;
    @(negedge clk);
    req_band = 4'd12; req_db = 4'd9; req_rng_a = 1;
    for (int k = 0; k < 30; k++) begin
      check(!req_ready, "R9 ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (HALF * 4) @(negedge clk);
    expect_words(base, 2, 8'h89, 8'h60, "R9 busy request ignored");

    // R7: reset clears band history
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({ser_clk, ser_stb, busy, req_ready} == 4'b0, "R1 outputs in second reset",
          {ser_clk, ser_stb, busy, req_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = ncap;
    send(4'd9, 1'b0, 1'b0, 1'b1, 4'd1);
    expect_words(base, 2, 8'h89, 8'h60, "R7 band resent after reset");
    base = ncap;
    send(4'd9, 1'b0, 1'b0, 1'b1, 4'd1);
    expect_words(base, 1, 8'h60, 8'h00, "R7 repeat skipped");
    // R3 R7: only a range bit differs
    base = ncap;
    send(4'd9, 1'b0, 1'b1, 1'b1, 4'd1);
    expect_words(base, 2, 8'h99, 8'h60, "R3 channel B range bit");

    repeat (10) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks + mchk, errors + merr);
    $finish;
  end

endmodule